// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt sources and reports them on two request outputs. Each source has a three-bit trigger code. The code chooses rising edge, falling edge, both edges, active-high level, active-low level or off. Edge events are caught in sticky latches. Software acknowledges them by writing ones to a clear address. Level sources are not stored: their pending state follows the input.

Each source has several control bits: an enable mask, a wake enable, an input selector and a route bit. The input selector picks one of two input vectors. The route bit sends the source to request 0 or to request 1. Every control register has a read address, a set address and a clear address. Writing a one to a set or clear address changes only the bits written as one. Software talks to the block through a simple synchronous port: writes take effect at the clock edge, and read data is registered.

Inputs pass through a synchronizer before any edge detection. A test register forces both requests high so the wiring beyond the block can be checked.

Top module: `edge_level_irq_ctl`

## Requirements
- R1: After reset, the cfg0, cfg1, cfg2, mask and wake registers read zero, the input-select and route registers read all ones, and req0_o, req1_o and wake_o are low.
- R2: The control registers use the kind numbers cfg0=0, cfg1=1, cfg2=2, mask=3, wake=4, input-select=5 and route=6. Kind k is read at word address 4k, set at 4k+1 and cleared at 4k+2. A one in the write data sets or clears that bit, and a zero leaves it unchanged.
- R3: The trigger code is {cfg2,cfg1,cfg0}. Code 001 latches rising edges, code 010 latches falling edges, and code 011 latches both, each into its own latch.
- R4: Code 101 makes a source pending while its synchronized input is high, and code 110 while it is low. Neither sets an edge latch. Codes 000, 100 and 111 never make a source pending.
- R5: An edge latch stays set after the input returns to idle. A write to address 30 clears the rising latches at the bits written as one, and a write to address 31 does the same for the falling latches. An either-edge source stays pending until both of its latches are cleared. The rising latches read at address 28 and the falling latches at address 29.
- R6: A pending source with its route bit set drives req0_o. With the route bit clear it drives req1_o.
- R7: A source reaches a request output only while its mask bit is set.
- R8: When a source's input-select bit is set, the source is taken from src_a_i. When the bit is clear, it is taken from src_b_i.
- R9: wake_o is high whenever a pending source has its wake bit set, whatever the state of its mask bit.
- R10: Address 32 reads the masked pending sources routed to request 0, and address 33 reads those routed to request 1.
- R11: Address 34 holds a one-bit test register. While it is 1, req0_o and req1_o are both forced high. Writing 0 restores normal operation.
- R12: bus_rdata_o holds the value of the address given with bus_rd_i, starting in the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| src_a_i | input | NSRC | Primary source inputs (asynchronous) |
| src_b_i | input | NSRC | Alternate source inputs (asynchronous) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake indication |

## Verification
The hardest state to reach is an either-edge source whose two latches are both set at the same time. The bench gets there by raising and then dropping the input while the source is configured. It then clears only the rising latch and checks that the request stays high. The input-select path needs the two input vectors driven to opposite values, so that a wrong choice shows as a wrong request level. Level sources are checked after the input returns to idle, because only that shows they were never latched.

// File: rtl/icu_pkg.sv
package icu_pkg;
   // Control register kinds; address of kind k: read 4k, set 4k+1, clear 4k+2
   localparam int unsigned KIND_N   = 7;
   localparam int unsigned KI_CFG0  = 0;
   localparam int unsigned KI_CFG1  = 1;
   localparam int unsigned KI_CFG2  = 2;
   localparam int unsigned KI_MASK  = 3;
   localparam int unsigned KI_WAKE  = 4;
   localparam int unsigned KI_SEL   = 5;
   localparam int unsigned KI_ROUTE = 6;
   localparam int unsigned OFS_SET  = 1;
   localparam int unsigned OFS_CLR  = 2;

   localparam int unsigned A_RISE_RD  = 28;
   localparam int unsigned A_FALL_RD  = 29;
   localparam int unsigned A_RISE_CLR = 30;
   localparam int unsigned A_FALL_CLR = 31;
   localparam int unsigned A_REQ0     = 32;
   localparam int unsigned A_REQ1     = 33;
   localparam int unsigned A_TEST     = 34;

   // Kinds whose bits reset to one
   localparam logic [KIND_N-1:0] ONES_AT_RESET = 7'b110_0000;

   // Trigger codes {cfg2,cfg1,cfg0}
   localparam logic [2:0] TRG_RISE = 3'b001;
   localparam logic [2:0] TRG_FALL = 3'b010;
   localparam logic [2:0] TRG_BOTH = 3'b011;
   localparam logic [2:0] TRG_HIGH = 3'b101;
   localparam logic [2:0] TRG_LOW  = 3'b110;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/icu_trig.sv
module icu_trig
   import icu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic [2:0] code,
   input  logic       rise_clr,
   input  logic       fall_clr,
   output logic       pend,
   output logic       rise_q,
   output logic       fall_q
);
   logic prev_q;
   logic rise_ev, fall_ev, rise_en, fall_en;

   assign rise_ev = lvl & ~prev_q;
   assign fall_ev = ~lvl & prev_q;
   assign rise_en = (code == TRG_RISE) || (code == TRG_BOTH);
   assign fall_en = (code == TRG_FALL) || (code == TRG_BOTH);

   // A new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         rise_q <= (rise_q & ~rise_clr) | (rise_en & rise_ev);
         fall_q <= (fall_q & ~fall_clr) | (fall_en & fall_ev);
      end
   end

   always_comb begin
      case (code)
         TRG_RISE: pend = rise_q;
         TRG_FALL: pend = fall_q;
         TRG_BOTH: pend = rise_q | fall_q;
         TRG_HIGH: pend = lvl;
         TRG_LOW:  pend = ~lvl;
         default:  pend = 1'b0;
      endcase
   end
endmodule

// File: rtl/edge_level_irq_ctl.sv
module edge_level_irq_ctl
   import icu_pkg::*;
#(
   parameter int unsigned NSRC        = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_a_i,
   input  logic [NSRC-1:0] src_b_i,
   input  logic            bus_wr_i,
   input  logic            bus_rd_i,
   input  logic [AW-1:0]   bus_addr_i,
   input  logic [DW-1:0]   bus_wdata_i,
   output logic [DW-1:0]   bus_rdata_o,
   output logic            req0_o,
   output logic            req1_o,
   output logic            wake_o
);
   if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
      $error("NSRC must lie between 1 and DW");
   end
   if (AW < 6) begin : g_bad_aw
      $error("AW must be at least 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [KIND_N-1:0][NSRC-1:0] creg;
   logic                        test_q;
   logic [NSRC-1:0]             wbits;
   logic [NSRC-1:0]             raw_v, lvl_v, pend_v, rise_v, fall_v;
   logic [NSRC-1:0]             mask_v, route_v, act0_v, act1_v;
   logic [NSRC-1:0]             rise_clr_v, fall_clr_v;
   logic [DW-1:0]               rd_mux;

   assign wbits = bus_wdata_i[NSRC-1:0];

   // Set/clear control registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < KIND_N; k++) creg[k] <= ONES_AT_RESET[k] ? '1 : '0;
         test_q <= 1'b0;
      end else if (bus_wr_i) begin
         for (int k = 0; k < KIND_N; k++) begin
            if (bus_addr_i == AW'(4*k + OFS_SET)) creg[k] <= creg[k] | wbits;
            else if (bus_addr_i == AW'(4*k + OFS_CLR)) creg[k] <= creg[k] & ~wbits;
         end
         if (bus_addr_i == AW'(A_TEST)) test_q <= bus_wdata_i[0];
      end
   end

   assign mask_v  = creg[KI_MASK];
   assign route_v = creg[KI_ROUTE];

   // Input selection ahead of the synchronizer
   assign raw_v = (creg[KI_SEL] & src_a_i) | (~creg[KI_SEL] & src_b_i);

   icu_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .d     (raw_v),
      .q     (lvl_v)
   );

   assign rise_clr_v = (bus_wr_i && bus_addr_i == AW'(A_RISE_CLR)) ? wbits : '0;
   assign fall_clr_v = (bus_wr_i && bus_addr_i == AW'(A_FALL_CLR)) ? wbits : '0;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      icu_trig u_trig (
         .clk      (clk_i),
         .rst_n    (rst_ni),
         .lvl      (lvl_v[i]),
         .code     ({creg[KI_CFG2][i], creg[KI_CFG1][i], creg[KI_CFG0][i]}),
         .rise_clr (rise_clr_v[i]),
         .fall_clr (fall_clr_v[i]),
         .pend     (pend_v[i]),
         .rise_q   (rise_v[i]),
         .fall_q   (fall_v[i])
      );
   end

   assign act0_v = pend_v & mask_v & route_v;
   assign act1_v = pend_v & mask_v & ~route_v;
   assign req0_o = test_q | (|act0_v);
   assign req1_o = test_q | (|act1_v);
   assign wake_o = |(pend_v & creg[KI_WAKE]);

   // Read path
   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < KIND_N; k++) begin
         if (bus_addr_i == AW'(4*k)) rd_mux = DW'(creg[k]);
      end
      if (bus_addr_i == AW'(A_RISE_RD)) rd_mux = DW'(rise_v);
      if (bus_addr_i == AW'(A_FALL_RD)) rd_mux = DW'(fall_v);
      if (bus_addr_i == AW'(A_REQ0))    rd_mux = DW'(act0_v);
      if (bus_addr_i == AW'(A_REQ1))    rd_mux = DW'(act1_v);
      if (bus_addr_i == AW'(A_TEST))    rd_mux = DW'(test_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_mux;
   end
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
   parameter int unsigned NSRC = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr,
   input logic [AW-1:0]   bus_addr,
   input logic [DW-1:0]   bus_wdata,
   input logic [NSRC-1:0] mask_q,
   input logic [NSRC-1:0] rise_q,
   input logic            test_q,
   input logic            req0,
   input logic            req1
);
   localparam logic [AW-1:0] A_MSET = AW'(13);
   localparam logic [AW-1:0] A_MCLR = AW'(14);
   localparam logic [AW-1:0] A_RCLR = AW'(30);

   AST_MASK_SET_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MSET) |=>
      ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R2

   AST_MASK_CLR_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MCLR) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R2

   AST_MASK_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_MSET || bus_addr == A_MCLR)) |=>
      (((mask_q ^ $past(mask_q)) & ~$past(bus_wdata[NSRC-1:0])) == '0)); // R2

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 && !test_q) |-> (!req0 && !req1)); // R7

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(rise_q) & ~rise_q)) |-> $past(bus_wr && bus_addr == A_RCLR)); // R5

   AST_TEST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      test_q |-> (req0 && req1)); // R11
endmodule

bind edge_level_irq_ctl icu_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .bus_wr    (bus_wr_i),
   .bus_addr  (bus_addr_i),
   .bus_wdata (bus_wdata_i),
   .mask_q    (mask_v),
   .rise_q    (rise_v),
   .test_q    (test_q),
   .req0      (req0_o),
   .req1      (req1_o)
);

// File: tb/edge_level_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module edge_level_irq_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_a = '0, src_b = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req0, req1, wake;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   edge_level_irq_ctl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_a_i(src_a), .src_b_i(src_b),
      .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .req0_o(req0), .req1_o(req1), .wake_o(wake)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic clean();
      wr(2, '1); wr(6, '1); wr(10, '1); wr(14, '1); wr(18, '1);
      wr(21, '1); wr(25, '1); wr(34, 0);
      src_a = '0; src_b = '0;
      tick(5);
      wr(30, '1); wr(31, '1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 req0", req0, 0); chk("R1 req1", req1, 0); chk("R1 wake", wake, 0);
      for (int k = 0; k < 7; k++) begin
         rd(6'(4*k), d);
         chk($sformatf("R1 kind %0d", k), d, (k >= 5) ? 32'hFFFF_FFFF : 32'h0);
      end
   endtask

   task automatic t_setclr();
      logic [31:0] d;
      wr(13, 32'h0000_F0F0); wr(13, 32'h0000_000F); wr(14, 32'h0000_00F0);
      rd(12, d); chk("R2 mask set/clear", d, 32'h0000_F00F);
      wr(26, 32'h1);
      rd(24, d); chk("R2 route clear one bit", d, 32'hFFFF_FFFE);
      rd(20, d); chk("R2 input-select untouched", d, 32'hFFFF_FFFF);
      clean();
   endtask

   task automatic t_rise();
      logic [31:0] d;
      wr(1, 1 << 3); wr(13, 1 << 3);
      src_a[3] = 1'b1; tick(5);
      chk("R3 rising sets req0", req0, 1);
      chk("R6 route set keeps req1 low", req1, 0);
      src_a[3] = 1'b0; tick(5);
      chk("R5 rising latch sticky", req0, 1);
      rd(28, d); chk("R5 rise latch read", d, 32'h8);
      wr(31, 1 << 3);
      chk("R5 fall clear leaves rise", req0, 1);
      wr(30, 1 << 3);
      chk("R5 rise clear drops req0", req0, 0);
      clean();
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(5, 1 << 5); wr(26, 1 << 5); wr(13, 1 << 5);
      src_a[5] = 1'b1; tick(5);
      chk("R3 falling ignores rise", req1, 0);
      src_a[5] = 1'b0; tick(5);
      chk("R3 falling sets req1", req1, 1);
      chk("R6 route clear keeps req0 low", req0, 0);
      rd(33, d); chk("R10 req1 status", d, 32'h20);
      wr(31, 1 << 5);
      chk("R5 fall clear drops req1", req1, 0);
      clean();
   endtask

   task automatic t_both();
      logic [31:0] d;
      wr(1, 1 << 7); wr(5, 1 << 7); wr(13, 1 << 7);
      src_a[7] = 1'b1; tick(5);
      src_a[7] = 1'b0; tick(5);
      chk("R3 both edges pending", req0, 1);
      rd(28, d); chk("R3 both rise latch", d, 32'h80);
      rd(29, d); chk("R3 both fall latch", d, 32'h80);
      wr(30, 1 << 7);
      chk("R5 either-edge needs both clears", req0, 1);
      wr(31, 1 << 7);
      chk("R5 either-edge cleared", req0, 0);
      clean();
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(1, 1 << 9); wr(9, 1 << 9); wr(13, 1 << 9);
      src_a[9] = 1'b1; tick(4);
      chk("R4 high level pending", req0, 1);
      src_a[9] = 1'b0; tick(4);
      chk("R4 high level not latched", req0, 0);
      wr(2, 1 << 9); wr(5, 1 << 9); tick(1);
      chk("R4 low level pending", req0, 1);
      wr(6, 1 << 9); tick(1);
      chk("R4 code 100 inert low", req0, 0);
      src_a[9] = 1'b1; tick(4);
      chk("R4 code 100 inert high", req0, 0);
      rd(28, d); chk("R4 no edge latch for level", d, 32'h0);
      clean();
   endtask

   task automatic t_mask_wake();
      logic [31:0] d;
      wr(1, 1 << 9); wr(9, 1 << 9);
      src_a[9] = 1'b1; tick(4);
      chk("R7 masked source quiet", req0, 0);
      rd(32, d); chk("R10 masked status empty", d, 32'h0);
      chk("R9 wake low without enable", wake, 0);
      wr(17, 1 << 9);
      chk("R9 wake despite mask", wake, 1);
      wr(13, 1 << 9);
      chk("R7 unmasked source requests", req0, 1);
      rd(32, d); chk("R10 req0 status", d, 32'h200);
      clean();
   endtask

   task automatic t_select();
      wr(1, 1 << 11); wr(9, 1 << 11); wr(13, 1 << 11); wr(22, 1 << 11);
      src_a[11] = 1'b1; tick(4);
      chk("R8 alternate selected ignores primary", req0, 0);
      src_b[11] = 1'b1; tick(4);
      chk("R8 alternate input drives", req0, 1);
      wr(21, 1 << 11); src_a[11] = 1'b0; tick(4);
      chk("R8 primary reselected", req0, 0);
      clean();
   endtask

   task automatic t_test();
      logic [31:0] d;
      wr(34, 1);
      chk("R11 test forces req0", req0, 1);
      chk("R11 test forces req1", req1, 1);
      rd(34, d); chk("R11 test read", d, 1);
      wr(34, 0);
      chk("R11 normal req0", req0, 0);
      chk("R11 normal req1", req1, 0);
   endtask

   task automatic t_readlat();
      wr(13, 32'h55);
      @(negedge clk); bus_addr = 12; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; bus_addr = 24;
      chk("R12 registered read data", bus_rdata, 32'h55);
      @(negedge clk);
      chk("R12 data held without strobe", bus_rdata, 32'h55);
      clean();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_setclr();
      t_rise();
      t_fall();
      t_both();
      t_level();
      t_mask_wake();
      t_select();
      t_test();
      t_readlat();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule